// File: doc/BRIEF.md
# Endian-Configurable Load Data Aligner

This block sits on the read path between a 32-bit external data bus and the destination register of a load. For each accepted request it takes the raw bus word, the two low address bits, the access size and an endian mode bit. It returns the value the load writes back. That value is a zero-extended byte, a halfword, or a whole word. On a non-aligned word or halfword access the word is rotated rather than faulted.

The mode bit only changes which bus lanes hold which memory byte. In little endian mode, memory byte 0 is on bits 7:0. In big endian mode, memory byte 0 is on bits 31:24. Word loads rotate right by eight bits per address offset, and the result is the same in either mode. Odd-offset halfword loads produce a rotated pattern whose top byte is not cleared.

Requests are captured on an input strobe. The result appears on the next clock edge with its own valid. The mode is sampled together with each request.

Top module: `rdata_aligner`

## Requirements
- R1: A synchronous active-high reset drives out_valid to 0 and out_data to 0.
- R2: out_valid is 1 exactly in the cycle after a cycle where in_valid is 1, and 0 after any cycle where in_valid is 0.
- R3: A word access (in_size 2'b10) returns in_data rotated right by 8 × in_ofs bits, identically in both modes (0x11223344 at offsets 0..3 gives 0x11223344, 0x44112233, 0x33441122, 0x22334411).
- R4: A little endian (in_big_end 0) halfword access (in_size 2'b01) selects bits 15:0 for offsets 0/1 and bits 31:16 for offsets 2/3. Even offsets zero-extend that halfword. Odd offsets return it rotated right by 8 with bits 23:8 zero (0x11223344 gives 0x00003344, 0x44000033, 0x00001122, 0x22000011).
- R5: A big endian (in_big_end 1) halfword access selects bits 31:16 for offsets 0/1 and bits 15:0 for offsets 2/3, with the same even/odd treatment as R4 (0x11223344 gives 0x00001122, 0x22000011, 0x00003344, 0x44000033).
- R6: A little endian byte access (in_size 2'b00) returns bus byte lane in_ofs (bits 8·ofs+7:8·ofs), zero-extended to 32 bits.
- R7: A big endian byte access returns bus byte lane 3 − in_ofs, zero-extended to 32 bits.
- R8: in_size 2'b11 behaves exactly as a word access.
- R9: While in_valid is 0, changes on in_data, in_ofs, in_size and in_big_end have no effect, and out_data holds the last result. The mode bit takes effect only through the request it accompanies, so back-to-back requests in different modes each follow their own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; inputs are captured when 1 |
| in_data | input | 32 | Raw word from the external bus |
| in_ofs | input | 2 | Low two address bits of the load |
| in_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 word |
| in_big_end | input | 1 | 1 = big endian lane order, 0 = little endian |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 32 | Aligned load result |

## Verification
The aligner keeps only one result register and a valid flag, so any wrong state is visible at the ports on the edge after the request that caused it. A wrong lane index or rotation amount shows up as misplaced bytes in that single result. A wrong mask leaves stray nonzero bits above a byte or halfword. A corrupted hold path makes out_data change during idle cycles. Back-to-back requests that alternate the mode expose any case where the mode is taken from the wrong cycle.

// File: rtl/rdal_pkg.sv
`timescale 1ns/1ps
package rdal_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

endpackage

// File: rtl/rdal_lane_sel.sv
`timescale 1ns/1ps
module rdal_lane_sel
    import rdal_pkg::*;
#(
    parameter int NUM_LANES = 4,
    localparam int OFS_W = $clog2(NUM_LANES)
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       size,
    input  logic             big_end,
    output logic [OFS_W-1:0] lane
);
    localparam logic [OFS_W-1:0] BYTE_FLIP = OFS_W'(NUM_LANES - 1);
    localparam logic [OFS_W-1:0] HALF_FLIP = OFS_W'(NUM_LANES - 2);

    logic [OFS_W-1:0] flip_d;

    always_comb begin
        flip_d = '0;
        if (big_end) begin
            case (acc_size_e'(size))
                SZ_BYTE: flip_d = BYTE_FLIP;
                SZ_HALF: flip_d = HALF_FLIP;
                default: flip_d = '0;
            endcase
        end
        lane = ofs ^ flip_d;
    end
endmodule

// File: rtl/rdal_rotator.sv
`timescale 1ns/1ps
module rdal_rotator #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 4,
    localparam int OFS_W  = $clog2(NUM_LANES),
    localparam int DATA_W = LANE_W * NUM_LANES
) (
    input  logic [DATA_W-1:0] din,
    input  logic [OFS_W-1:0]  shift,
    output logic [DATA_W-1:0] dout
);
    logic [NUM_LANES-1:0][LANE_W-1:0] in_lanes;
    assign in_lanes = din;

    for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
        localparam logic [OFS_W-1:0] POS = OFS_W'(j);
        logic [OFS_W-1:0] src_d;
        assign src_d = POS + shift;
        assign dout[j*LANE_W +: LANE_W] = in_lanes[src_d];
    end

    always_comb begin
        if (!$isunknown({din, shift})) begin
            // R3
            pop_keep_chk: assert ($countones(dout) == $countones(din));
        end
    end
endmodule

// File: rtl/rdal_masker.sv
`timescale 1ns/1ps
module rdal_masker
    import rdal_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 4,
    localparam int DATA_W = LANE_W * NUM_LANES
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        size,
    input  logic              lane_odd,
    output logic [DATA_W-1:0] dout
);
    logic [NUM_LANES-1:0] keep_d;

    for (genvar j = 0; j < NUM_LANES; j++) begin : g_keep
        always_comb begin
            case (acc_size_e'(size))
                SZ_BYTE: keep_d[j] = (j == 0);
                SZ_HALF: keep_d[j] = lane_odd ? (j == 0 || j == NUM_LANES - 1)
                                              : (j == 0 || j == 1);
                default: keep_d[j] = 1'b1;
            endcase
        end
        assign dout[j*LANE_W +: LANE_W] = keep_d[j] ? din[j*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/rdata_aligner.sv
`timescale 1ns/1ps
module rdata_aligner
    import rdal_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 4,
    localparam int OFS_W  = $clog2(NUM_LANES),
    localparam int DATA_W = LANE_W * NUM_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    input  logic [1:0]        in_ofs,
    input  logic [1:0]        in_size,
    input  logic              in_big_end,
    output logic              out_valid,
    output logic [31:0]       out_data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t st_d, st_q;

    logic [OFS_W-1:0]  lane;
    logic [DATA_W-1:0] rot_data;
    logic [DATA_W-1:0] mask_data;

    rdal_lane_sel #(.NUM_LANES(NUM_LANES)) i_lane_sel (
        .ofs     (in_ofs[OFS_W-1:0]),
        .size    (in_size),
        .big_end (in_big_end),
        .lane    (lane)
    );

    rdal_rotator #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) i_rotator (
        .din   (in_data[DATA_W-1:0]),
        .shift (lane),
        .dout  (rot_data)
    );

    rdal_masker #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) i_masker (
        .din      (rot_data),
        .size     (in_size),
        .lane_odd (lane[0]),
        .dout     (mask_data)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = mask_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = 32'(st_q.data);

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6 R7
    byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b00) |=> (out_data[31:8] == '0));

    // R4 R5
    half_even_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b01 && !in_ofs[0]) |=> (out_data[31:16] == '0));

    // R4 R5
    half_odd_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b01 && in_ofs[0]) |=> (out_data[23:8] == '0));

    // R3 R8
    word_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size[1]) |=> ($countones(out_data) == $countones($past(in_data))));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
endmodule

// File: tb/test_rdata_aligner.sv
`timescale 1ns/1ps
module test_rdata_aligner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_ofs = '0;
    logic [1:0]  in_size = '0;
    logic        in_big_end = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rdata_aligner i_rdata_aligner (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ofs     (in_ofs),
        .in_size    (in_size),
        .in_big_end (in_big_end),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    function automatic logic [31:0] ror8(input logic [31:0] v, input int n);
        logic [31:0] r = v;
        for (int i = 0; i < n; i++) r = {r[7:0], r[31:8]};
        return r;
    endfunction

    function automatic logic [31:0] model(input logic be, input logic [1:0] sz,
                                          input logic [1:0] ofs, input logic [31:0] d);
        logic [7:0] m [4];
        logic [15:0] h;
        int a;
        for (int i = 0; i < 4; i++) m[i] = be ? d[8*(3-i) +: 8] : d[8*i +: 8];
        if (sz[1]) return ror8(d, int'(ofs));
        if (sz == 2'b00) return {24'h0, m[ofs]};
        a = ofs[1] ? 2 : 0;
        h = be ? {m[a], m[a+1]} : {m[a+1], m[a]};
        return ofs[0] ? ror8({16'h0, h}, 1) : {16'h0, h};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one request right after a negedge, check at the next negedge
    task automatic issue(input string req, input logic be, input logic [1:0] sz,
                         input logic [1:0] ofs, input logic [31:0] d, input logic [31:0] exp);
        in_valid = 1'b1; in_big_end = be; in_size = sz; in_ofs = ofs; in_data = d;
        @(negedge clk);
        check({req, " valid"}, {31'h0, out_valid}, 32'h1);
        check(req, out_data, exp);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 valid", {31'h0, out_valid}, 32'h0);
        check("R1 data", out_data, 32'h0);
        rst = 1'b0;
        idle();
        check("R2 idle valid", {31'h0, out_valid}, 32'h0);
    endtask

    task automatic test_table();
        logic [31:0] t [24] = '{
            32'h11223344, 32'h44112233, 32'h33441122, 32'h22334411,   // R3 LE word
            32'h11223344, 32'h44112233, 32'h33441122, 32'h22334411,   // R3 BE word
            32'h00003344, 32'h44000033, 32'h00001122, 32'h22000011,   // R4
            32'h00001122, 32'h22000011, 32'h00003344, 32'h44000033,   // R5
            32'h00000044, 32'h00000033, 32'h00000022, 32'h00000011,   // R6
            32'h00000011, 32'h00000022, 32'h00000033, 32'h00000044    // R7
        };
        string tags [6] = '{"R3 le word", "R3 be word", "R4 le half", "R5 be half",
                            "R6 le byte", "R7 be byte"};
        logic [1:0] szs [6] = '{2'b10, 2'b10, 2'b01, 2'b01, 2'b00, 2'b00};
        for (int g = 0; g < 6; g++) begin
            for (int o = 0; o < 4; o++) begin
                issue(tags[g], logic'(g % 2), szs[g], 2'(o), 32'h11223344, t[g*4+o]);
            end
        end
        idle();
        check("R2 valid drops", {31'h0, out_valid}, 32'h0);
    endtask

    task automatic test_size3();
        for (int o = 0; o < 4; o++) begin
            issue("R8 size3 le", 1'b0, 2'b11, 2'(o), 32'hA1B2C3D4, ror8(32'hA1B2C3D4, o));
            issue("R8 size3 be", 1'b1, 2'b11, 2'(o), 32'h0F1E2D3C, ror8(32'h0F1E2D3C, o));
        end
        idle();
    endtask

    task automatic test_hold();
        issue("R9 load", 1'b0, 2'b00, 2'd1, 32'hCAFEBABE, 32'h000000BA);
        in_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            in_big_end = ~in_big_end; in_data = $urandom; in_ofs = 2'(i); in_size = 2'(i);
            @(negedge clk);
            check("R9 held data", out_data, 32'h000000BA);
            check("R9 held valid", {31'h0, out_valid}, 32'h0);
        end
    endtask

    task automatic test_mode_switch();
        issue("R9 le", 1'b0, 2'b00, 2'd0, 32'h11223344, 32'h00000044);
        issue("R9 be", 1'b1, 2'b00, 2'd0, 32'h11223344, 32'h00000011);
        issue("R9 le", 1'b0, 2'b01, 2'd1, 32'h11223344, 32'h44000033);
        issue("R9 be", 1'b1, 2'b01, 2'd1, 32'h11223344, 32'h22000011);
        idle();
    endtask

    task automatic test_random();
        for (int i = 0; i < 300; i++) begin
            logic        be  = 1'($urandom);
            logic [1:0]  sz  = 2'($urandom);
            logic [1:0]  ofs = 2'($urandom);
            logic [31:0] d   = $urandom;
            issue("R3-R8 random (R3 R4 R5 R6 R7 R8)", be, sz, ofs, d, model(be, sz, ofs, d));
            if (i % 7 == 0) idle();
        end
        idle();
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_table();
        test_size3();
        test_hold();
        test_mode_switch();
        test_random();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule